// File: doc/BRIEF.md
# Dual-Issue Instruction Sequencer with Hardware Repeat

This block sits between the fetch path and the execution units of a processor that packs either one wide operation or two narrow operations into each 32-bit instruction word. Every cycle it looks at the word fetched from the current program counter, reads its two-bit format code, and sends one 30-bit long operation, one 15-bit short operation, or two 15-bit short operations at once to the execution units. A word holding two short operations may ask for them one after the other, in either order, or together in the same cycle.

The execution units report back in the same cycle whether the operation just issued took a branch, and where to, and whether it raised an exception. A branch taken by the first operation of a sequential pair cancels the second one. An exception freezes the sequencer until an external resume. A zero-overhead repeat loop can be armed with start address, end address and count. Once armed, it sends the program counter back to the loop start each time the end word finishes, and it needs no extra cycles to do so. Event counters record issue cycles, words of each format, and cancelled second operations.

Top module: `dual_issue_seq`

## Requirements
- R1: While reset is held, the program counter is RESET_PC (0), the sequencer is not halted, the repeat loop is inactive and all six event counters read zero.
- R2: Format code 2'b11 in word bits [31:30] issues one long operation carrying bits [29:0] in a single cycle, with no short strobe. Without a branch or repeat the counter then advances by one.
- R3: Format code 2'b01 issues the left container (bits [29:15]) alone in the first cycle and the right container (bits [14:0]) alone in the next cycle. The program counter is unchanged between the two.
- R4: Format code 2'b10 issues the right container (bits [14:0]) first and the left container (bits [29:15]) in the following cycle.
- R5: Format code 2'b00 issues both containers in the same cycle, and the word completes in that cycle.
- R6: If the first operation of a sequential pair reports a taken branch without an exception, the second operation never issues. The next cycle fetches from the branch target.
- R7: A taken branch reported without an exception on the last (or only) issue of a word loads the branch target as the next program counter.
- R8: A repeat load with a nonzero count arms the loop; a zero count disarms it. A load overrides any loop update in the same cycle. When an armed word at the end address completes without a branch and the count is above one, the count drops by one and the program counter loads the start address. When the count is one, the loop disarms and the counter advances by one.
- R9: An exception on any issue halts the sequencer from the next cycle. It then shows no strobes, and the program counter stays on the faulting word. A taken branch reported in the same cycle is ignored. A resume while halted restarts that word from its first container in the following cycle. A resume while running has no effect.
- R10: The cycle counter increments on every non-halted cycle. The long, left-then-right, right-then-left and parallel counters increment when a word of that format makes its first issue. The skip counter increments on each R6 cancellation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_pc_o | output | PC_W | Word address of the instruction being issued |
| fetch_word_i | input | 32 | Instruction word at fetch_pc_o, valid in the same cycle |
| br_taken_i | input | 1 | Issued operation took a branch this cycle |
| br_target_i | input | PC_W | Branch target word address |
| exc_i | input | 1 | Issued operation raised an exception this cycle |
| resume_i | input | 1 | Leave the halted state |
| rpt_load_i | input | 1 | Load the repeat loop registers |
| rpt_start_i | input | PC_W | Loop start word address |
| rpt_end_i | input | PC_W | Loop end word address |
| rpt_count_i | input | RC_W | Number of loop passes |
| long_vld_o | output | 1 | Long operation strobe |
| long_op_o | output | 30 | Long operation payload |
| left_vld_o | output | 1 | Left container strobe |
| left_op_o | output | 15 | Left container payload |
| right_vld_o | output | 1 | Right container strobe |
| right_op_o | output | 15 | Right container payload |
| halted_o | output | 1 | Sequencer frozen after an exception |
| rpt_active_o | output | 1 | Repeat loop armed |
| cyc_cnt_o | output | CNT_W | Issue cycles |
| long_cnt_o | output | CNT_W | Long words |
| lr_cnt_o | output | CNT_W | Left-then-right words |
| rl_cnt_o | output | CNT_W | Right-then-left words |
| par_cnt_o | output | CNT_W | Parallel words |
| skip_cnt_o | output | CNT_W | Second operations cancelled by a branch |

## Verification
The bound assertions check several rules on every cycle. A long strobe never shares a cycle with a short one, a parallel word always fires both containers, and a halted sequencer is silent with a frozen counter. An exception always leads to the halted state, a left-first pair always follows with its right half at the same address, a cancelled pair always lands on the branch target, and the cycle counter steps once per running cycle. The repeat loop's count-down and exit, resume restarting the first container, and the per-format counter totals depend on histories many words long. Only the bench's long mixed run shows these, with a reference model compared against every output on every cycle.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    FMT_PAR  = 2'b00,
    FMT_LR   = 2'b01,
    FMT_RL   = 2'b10,
    FMT_LONG = 2'b11
  } fmt_e;

  localparam int EV_N    = 6;
  localparam int EV_CYC  = 0;
  localparam int EV_LONG = 1;
  localparam int EV_LR   = 2;
  localparam int EV_RL   = 3;
  localparam int EV_PAR  = 4;
  localparam int EV_SKIP = 5;
endpackage

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
(
  input  logic [31:0] word,
  input  logic        phase,
  input  logic        run,
  output fmt_e        fmt,
  output logic        is_seq,
  output logic        long_vld,
  output logic [29:0] long_op,
  output logic        left_vld,
  output logic [14:0] left_op,
  output logic        right_vld,
  output logic [14:0] right_op
);
  always_comb begin
    fmt       = fmt_e'(word[31:30]);
    long_op   = word[29:0];
    left_op   = word[29:15];
    right_op  = word[14:0];
    is_seq    = (fmt == FMT_LR) || (fmt == FMT_RL);
    long_vld  = 1'b0;
    left_vld  = 1'b0;
    right_vld = 1'b0;
    if (run) begin
      unique case (fmt)
        FMT_LONG: long_vld = 1'b1;
        FMT_PAR: begin
          left_vld  = 1'b1;
          right_vld = 1'b1;
        end
        FMT_LR: begin
          left_vld  = ~phase;
          right_vld = phase;
        end
        FMT_RL: begin
          right_vld = ~phase;
          left_vld  = phase;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic is_seq,
  input  logic br_taken,
  input  logic exc,
  input  logic resume,
  output logic run,
  output logic phase,
  output logic halted,
  output logic word_end,
  output logic skip
);
  logic phase_nx, halted_nx;

  always_comb begin
    run      = ~halted;
    word_end = run & ~exc & (~is_seq | phase | br_taken);
    skip     = run & ~exc & is_seq & ~phase & br_taken;
    phase_nx  = phase;
    halted_nx = halted;
    if (run) begin
      if (exc) begin
        halted_nx = 1'b1;
        phase_nx  = 1'b0;
      end else if (word_end) begin
        phase_nx = 1'b0;
      end else begin
        phase_nx = 1'b1;
      end
    end else if (resume) begin
      halted_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= 1'b0;
      halted <= 1'b0;
    end else begin
      phase  <= phase_nx;
      halted <= halted_nx;
    end
  end
endmodule

// File: rtl/seq_pc_rpt.sv
module seq_pc_rpt #(
  parameter int          PC_W     = 16,
  parameter int          RC_W     = 8,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            word_end,
  input  logic            br_taken,
  input  logic [PC_W-1:0] br_target,
  input  logic            rpt_load,
  input  logic [PC_W-1:0] rpt_start,
  input  logic [PC_W-1:0] rpt_end,
  input  logic [RC_W-1:0] rpt_count,
  output logic [PC_W-1:0] pc,
  output logic            rpt_active
);
  localparam logic [RC_W-1:0] ONE = RC_W'(1);

  logic [PC_W-1:0] pc_nx, rs_q, rs_nx, re_q, re_nx;
  logic [RC_W-1:0] rc_q, rc_nx;
  logic            ract_nx;

  always_comb begin
    pc_nx   = pc;
    rs_nx   = rs_q;
    re_nx   = re_q;
    rc_nx   = rc_q;
    ract_nx = rpt_active;
    if (word_end) begin
      if (br_taken) begin
        pc_nx = br_target;
      end else if (rpt_active && (pc == re_q)) begin
        if (rc_q == ONE) begin
          ract_nx = 1'b0;
          rc_nx   = '0;
          pc_nx   = pc + PC_W'(1);
        end else begin
          rc_nx = rc_q - ONE;
          pc_nx = rs_q;
        end
      end else begin
        pc_nx = pc + PC_W'(1);
      end
    end
    if (rpt_load) begin
      rs_nx   = rpt_start;
      re_nx   = rpt_end;
      rc_nx   = rpt_count;
      ract_nx = |rpt_count;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc         <= RESET_PC;
      rs_q       <= '0;
      re_q       <= '0;
      rc_q       <= '0;
      rpt_active <= 1'b0;
    end else begin
      pc         <= pc_nx;
      rs_q       <= rs_nx;
      re_q       <= re_nx;
      rc_q       <= rc_nx;
      rpt_active <= ract_nx;
    end
  end
endmodule

// File: rtl/seq_evt_cnt.sv
module seq_evt_cnt #(
  parameter int N = 6,
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N-1:0]        ev,
  output logic [N-1:0][W-1:0] cnt
);
  for (genvar g = 0; g < N; g++) begin : g_cnt
    logic [W-1:0] nx;
    always_comb nx = ev[g] ? cnt[g] + W'(1) : cnt[g];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt[g] <= '0;
      else        cnt[g] <= nx;
    end
  end
endmodule

// File: rtl/dual_issue_seq.sv
module dual_issue_seq
  import seq_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int RC_W  = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [PC_W-1:0]  fetch_pc_o,
  input  logic [31:0]      fetch_word_i,
  input  logic             br_taken_i,
  input  logic [PC_W-1:0]  br_target_i,
  input  logic             exc_i,
  input  logic             resume_i,
  input  logic             rpt_load_i,
  input  logic [PC_W-1:0]  rpt_start_i,
  input  logic [PC_W-1:0]  rpt_end_i,
  input  logic [RC_W-1:0]  rpt_count_i,
  output logic             long_vld_o,
  output logic [29:0]      long_op_o,
  output logic             left_vld_o,
  output logic [14:0]      left_op_o,
  output logic             right_vld_o,
  output logic [14:0]      right_op_o,
  output logic             halted_o,
  output logic             rpt_active_o,
  output logic [CNT_W-1:0] cyc_cnt_o,
  output logic [CNT_W-1:0] long_cnt_o,
  output logic [CNT_W-1:0] lr_cnt_o,
  output logic [CNT_W-1:0] rl_cnt_o,
  output logic [CNT_W-1:0] par_cnt_o,
  output logic [CNT_W-1:0] skip_cnt_o
);
  fmt_e                       fmt;
  logic                       is_seq, run, phase, word_end, skip, first;
  logic [EV_N-1:0]            ev;
  logic [EV_N-1:0][CNT_W-1:0] cnt;

  seq_decode u_dec (
    .word(fetch_word_i), .phase(phase), .run(run), .fmt(fmt), .is_seq(is_seq),
    .long_vld(long_vld_o), .long_op(long_op_o),
    .left_vld(left_vld_o), .left_op(left_op_o),
    .right_vld(right_vld_o), .right_op(right_op_o)
  );

  seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .is_seq(is_seq), .br_taken(br_taken_i),
    .exc(exc_i), .resume(resume_i), .run(run), .phase(phase),
    .halted(halted_o), .word_end(word_end), .skip(skip)
  );

  seq_pc_rpt #(.PC_W(PC_W), .RC_W(RC_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .word_end(word_end), .br_taken(br_taken_i),
    .br_target(br_target_i), .rpt_load(rpt_load_i), .rpt_start(rpt_start_i),
    .rpt_end(rpt_end_i), .rpt_count(rpt_count_i), .pc(fetch_pc_o),
    .rpt_active(rpt_active_o)
  );

  always_comb begin
    first         = run & ~phase;
    ev[EV_CYC]    = run;
    ev[EV_LONG]   = first & (fmt == FMT_LONG);
    ev[EV_LR]     = first & (fmt == FMT_LR);
    ev[EV_RL]     = first & (fmt == FMT_RL);
    ev[EV_PAR]    = first & (fmt == FMT_PAR);
    ev[EV_SKIP]   = skip;
  end

  seq_evt_cnt #(.N(EV_N), .W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .ev(ev), .cnt(cnt)
  );

  assign cyc_cnt_o  = cnt[EV_CYC];
  assign long_cnt_o = cnt[EV_LONG];
  assign lr_cnt_o   = cnt[EV_LR];
  assign rl_cnt_o   = cnt[EV_RL];
  assign par_cnt_o  = cnt[EV_PAR];
  assign skip_cnt_o = cnt[EV_SKIP];
endmodule

// File: rtl/seq_chk.sv
module seq_chk #(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PC_W-1:0]  fetch_pc_o,
  input logic [31:0]      fetch_word_i,
  input logic             br_taken_i,
  input logic [PC_W-1:0]  br_target_i,
  input logic             exc_i,
  input logic             long_vld_o,
  input logic             left_vld_o,
  input logic             right_vld_o,
  input logic             halted_o,
  input logic             rpt_active_o,
  input logic [CNT_W-1:0] cyc_cnt_o
);
  // R2
  long_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    long_vld_o |-> (!left_vld_o && !right_vld_o));

  // R2
  long_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (long_vld_o && !br_taken_i && !exc_i && !rpt_active_o)
      |=> fetch_pc_o == PC_W'($past(fetch_pc_o) + PC_W'(1)));

  // R3
  lr_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_word_i[31:30] == 2'b01 && left_vld_o && !br_taken_i && !exc_i)
      |=> (right_vld_o && !left_vld_o && $stable(fetch_pc_o)));

  // R5
  par_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted_o && fetch_word_i[31:30] == 2'b00) |-> (left_vld_o && right_vld_o));

  // R6
  skip_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_word_i[31:30] == 2'b01 && left_vld_o && br_taken_i && !exc_i)
      |=> fetch_pc_o == $past(br_target_i));

  // R9
  exc_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halted_o && exc_i) |=> halted_o);

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |-> !(long_vld_o || left_vld_o || right_vld_o));

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> $stable(fetch_pc_o));

  // R10
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !halted_o |=> cyc_cnt_o == CNT_W'($past(cyc_cnt_o) + CNT_W'(1)));
endmodule

bind dual_issue_seq seq_chk #(.PC_W(PC_W), .CNT_W(CNT_W)) u_seq_chk (
  .clk(clk), .rst_n(rst_n), .fetch_pc_o(fetch_pc_o), .fetch_word_i(fetch_word_i),
  .br_taken_i(br_taken_i), .br_target_i(br_target_i), .exc_i(exc_i),
  .long_vld_o(long_vld_o), .left_vld_o(left_vld_o), .right_vld_o(right_vld_o),
  .halted_o(halted_o), .rpt_active_o(rpt_active_o), .cyc_cnt_o(cyc_cnt_o)
);

// File: tb/tb_dual_issue_seq.sv
module tb_dual_issue_seq;
  localparam int PC_W = 16, RC_W = 8, CNT_W = 16, NCYC = 6000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n;
  logic [PC_W-1:0]  fetch_pc_o, br_target_i, rpt_start_i, rpt_end_i;
  logic [31:0]      fetch_word_i;
  logic             br_taken_i, exc_i, resume_i, rpt_load_i;
  logic [RC_W-1:0]  rpt_count_i;
  logic             long_vld_o, left_vld_o, right_vld_o, halted_o, rpt_active_o;
  logic [29:0]      long_op_o;
  logic [14:0]      left_op_o, right_op_o;
  logic [CNT_W-1:0] cyc_cnt_o, long_cnt_o, lr_cnt_o, rl_cnt_o, par_cnt_o, skip_cnt_o;

  logic [31:0] mem [0:63];
  assign fetch_word_i = mem[fetch_pc_o[5:0]];

  dual_issue_seq #(.PC_W(PC_W), .RC_W(RC_W), .CNT_W(CNT_W)) dut (.*);

  int vecs = 0, errs = 0;

  // reference state
  logic [PC_W-1:0]  m_pc, m_rs, m_re;
  logic [RC_W-1:0]  m_rc;
  logic             m_phase, m_halt, m_ract;
  logic [CNT_W-1:0] m_cnt [0:5];
  string            m_tag;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    logic [31:0] w;
    logic [1:0]  f;
    logic        run, e_long, e_l, e_r;
    string       st;
    w   = mem[m_pc[5:0]];
    f   = w[31:30];
    run = ~m_halt;
    e_long = run && f == 2'b11;
    e_l = run && (f == 2'b00 || (f == 2'b01 && !m_phase) || (f == 2'b10 && m_phase));
    e_r = run && (f == 2'b00 || (f == 2'b01 && m_phase) || (f == 2'b10 && !m_phase));
    if (m_halt)          st = "R9";
    else if (f == 2'b11) st = "R2";
    else if (f == 2'b01) st = "R3";
    else if (f == 2'b10) st = "R4";
    else                 st = "R5";
    chk(m_tag, "pc", 32'(fetch_pc_o), 32'(m_pc));
    chk(st, "long_vld", 32'(long_vld_o), 32'(e_long));
    chk(st, "left_vld", 32'(left_vld_o), 32'(e_l));
    chk(st, "right_vld", 32'(right_vld_o), 32'(e_r));
    if (e_long) chk("R2", "long_op", 32'(long_op_o), 32'(w[29:0]));
    if (e_l)    chk(st, "left_op", 32'(left_op_o), 32'(w[29:15]));
    if (e_r)    chk(st, "right_op", 32'(right_op_o), 32'(w[14:0]));
    chk("R9", "halted", 32'(halted_o), 32'(m_halt));
    chk("R8", "rpt_active", 32'(rpt_active_o), 32'(m_ract));
    chk("R10", "cyc_cnt", 32'(cyc_cnt_o), 32'(m_cnt[0]));
    chk("R10", "long_cnt", 32'(long_cnt_o), 32'(m_cnt[1]));
    chk("R10", "lr_cnt", 32'(lr_cnt_o), 32'(m_cnt[2]));
    chk("R10", "rl_cnt", 32'(rl_cnt_o), 32'(m_cnt[3]));
    chk("R10", "par_cnt", 32'(par_cnt_o), 32'(m_cnt[4]));
    chk("R10", "skip_cnt", 32'(skip_cnt_o), 32'(m_cnt[5]));
  endtask

  task automatic step();
    logic [1:0] f;
    logic       seq;
    f   = mem[m_pc[5:0]][31:30];
    seq = (f == 2'b01) || (f == 2'b10);
    if (!m_halt) begin
      m_cnt[0]++;
      if (!m_phase) begin
        case (f)
          2'b11: m_cnt[1]++;
          2'b01: m_cnt[2]++;
          2'b10: m_cnt[3]++;
          default: m_cnt[4]++;
        endcase
      end
      if (exc_i) begin
        m_halt = 1'b1; m_phase = 1'b0; m_tag = "R9";
      end else if (seq && !m_phase && !br_taken_i) begin
        m_phase = 1'b1; m_tag = (f == 2'b01) ? "R3" : "R4";
      end else begin
        if (seq && !m_phase) begin m_cnt[5]++; m_tag = "R6"; end
        else m_tag = "R7";
        m_phase = 1'b0;
        if (br_taken_i) m_pc = br_target_i;
        else if (m_ract && m_pc == m_re) begin
          m_tag = "R8";
          if (m_rc == 1) begin m_ract = 1'b0; m_rc = '0; m_pc = m_pc + 1; end
          else begin m_rc = m_rc - 1; m_pc = m_rs; end
        end else begin
          m_pc = m_pc + 1;
          m_tag = (f == 2'b11) ? "R2" : (f == 2'b00) ? "R5" : (f == 2'b01) ? "R3" : "R4";
        end
      end
    end else begin
      m_tag = "R9";
      if (resume_i) m_halt = 1'b0;
    end
    if (rpt_load_i) begin
      m_rs = rpt_start_i; m_re = rpt_end_i; m_rc = rpt_count_i;
      m_ract = (rpt_count_i != 0);
      m_tag = "R8";
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL R1 watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    br_taken_i = 0; br_target_i = '0; exc_i = 0; resume_i = 0;
    rpt_load_i = 0; rpt_start_i = '0; rpt_end_i = '0; rpt_count_i = '0;
    for (int i = 0; i < 64; i++) mem[i] = $urandom;
    mem[0] = {2'b01, 30'h1234_5678};
    m_pc = '0; m_rs = '0; m_re = '0; m_rc = '0;
    m_phase = 0; m_halt = 0; m_ract = 0; m_tag = "R1";
    for (int i = 0; i < 6; i++) m_cnt[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "pc", 32'(fetch_pc_o), 32'h0);
    chk("R1", "halted", 32'(halted_o), 32'h0);
    chk("R1", "rpt_active", 32'(rpt_active_o), 32'h0);
    chk("R1", "cyc_cnt", 32'(cyc_cnt_o), 32'h0);
    chk("R1", "skip_cnt", 32'(skip_cnt_o), 32'h0);
    rst_n = 1'b1;
    for (int c = 0; c < NCYC; c++) begin
      if (c != 0) @(negedge clk);
      compare();
      br_taken_i  = ($urandom % 7) == 0;
      br_target_i = PC_W'($urandom % 64);
      exc_i       = ($urandom % 37) == 0;
      resume_i    = ($urandom % 3) == 0;
      rpt_load_i  = ($urandom % 45) == 0;
      rpt_start_i = m_pc;
      rpt_end_i   = m_pc + PC_W'($urandom % 4);
      rpt_count_i = RC_W'($urandom % 4);
      step();
    end
    @(negedge clk);
    compare();
    finish_run();
  end
endmodule